// File: doc/BRIEF.md
# Single-Shot Bit-Flip Injection Controller

This block sits in front of a bank of R flip-flops and can upset exactly one of them, once, for a single clock cycle. Every flip-flop of the bank takes its next value through a two-way selector. The selector either passes the true next-state value or its complement. A P-bit index picks which selector, if any, takes the complement path in the current cycle.

The index is one-based. A value of zero means "leave the bank alone". Values 1 through R name flip-flop 0 through R-1. Values above R are treated as no request. A sticky state bit records the first cycle in which a flip was applied. From that point on every select line is held low, whatever the index does, until the next reset. So each reset-to-reset run holds at most one corrupted bit in one cycle.

The block is meant for fault-model experiments. A stimulus source (here the testbench) drives the index, and the captured bank is compared with its fault-free twin. The block exposes two status outputs: a flag that says the flip has happened, and the index that caused it.

Top module: `flip_once_injector`

## Requirements
- R1: While reset is asserted and right after it, the bank output is all zeros, the injected flag is 0 and the recorded index is 0.
- R2: When the index is 0, every bank bit captures its true next-state value at the next rising clock edge.
- R3: In any cycle, at most one bank bit captures an inverted value.
- R4: In the first cycle after reset where the index k satisfies 1 <= k <= R, bank bit k-1 captures the complement of its next-state value at the next edge, and all other bits capture true values. The injected flag rises at that same edge.
- R5: Once set, the injected flag stays at 1 until reset.
- R6: While the injected flag is 1, no bank bit is inverted for any index value.
- R7: An index greater than R causes no inversion and leaves the injected flag at 0.
- R8: The recorded index output is 0 until an injection occurs. At the injecting edge it takes the value of the injecting index, and it then holds that value until reset.
- R9: Asserting reset re-arms the block, so the next in-range index causes a new single flip.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous active-low reset |
| fault_idx_i | input | P | One-based bit-flip index; 0 or a value above R means no flip |
| d_i | input | R | Fault-free next-state values of the target bank |
| q_o | output | R | Bank contents as captured, including any injected flip |
| injected_o | output | 1 | High once the single flip has been applied |
| fault_idx_q_o | output | P | Index that caused the flip, 0 before it |

## Verification
Four properties are checked on every cycle: that at most one select line is active, that the select lines stay silent once the flag is set, that the flag never falls, and that the recorded index does not move after injection. Also checked every cycle: a zero or out-of-range index leaves the captured bank equal to its input, and an in-range first request flips exactly one bit. Only the bench scenarios can show the whole story of a run: which bit was flipped for a given index at both ends of the range (1 and R), that exactly one cycle of each run carries a flip, and that reset re-arms the block for a fresh run.

// File: rtl/flip_once_pkg.sv
package flip_once_pkg;

  // Arming state of the single-shot injector.
  typedef enum logic {
    INJ_ARMED = 1'b0,
    INJ_SPENT = 1'b1
  } inj_state_e;

endpackage

// File: rtl/flip_sel_decoder.sv
// Index-to-select decoder. Output code 0 of a full P-to-2^P decoder is
// dropped, and codes 1..R drive the R select lines; codes above R have
// no line. Only lines that exist are built.
module flip_sel_decoder #(
  parameter int unsigned P = 4,
  parameter int unsigned R = 8
) (
  input  logic [P-1:0] idx_i,
  input  logic         enable_i,
  output logic [R-1:0] sel_o
);

  for (genvar g = 0; g < R; g++) begin : g_line
    localparam logic [P-1:0] CODE = P'(g + 1);
    always_comb begin
      sel_o[g] = enable_i && (idx_i == CODE);
    end
  end

endmodule

// File: rtl/flip_once_latch.sv
// Sticky arming state: armed after reset, spent after the first flip.
module flip_once_latch
  import flip_once_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       fire_i,
  output inj_state_e state_o
);

  inj_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (state_q == INJ_ARMED && fire_i) begin
      state_d = INJ_SPENT;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= INJ_ARMED;
    end else begin
      state_q <= state_d;
    end
  end

  assign state_o = state_q;

endmodule

// File: rtl/flip_mux_bank.sv
// One true/complement selector in front of each bank flip-flop.
module flip_mux_bank #(
  parameter int unsigned R = 8
) (
  input  logic [R-1:0] d_i,
  input  logic [R-1:0] sel_i,
  output logic [R-1:0] mux_o
);

  for (genvar g = 0; g < R; g++) begin : g_mux
    always_comb begin
      mux_o[g] = sel_i[g] ? ~d_i[g] : d_i[g];
    end
  end

endmodule

// File: rtl/flip_once_injector.sv
module flip_once_injector
  import flip_once_pkg::*;
#(
  parameter int unsigned R = 8,
  parameter int unsigned P = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [P-1:0] fault_idx_i,
  input  logic [R-1:0] d_i,
  output logic [R-1:0] q_o,
  output logic         injected_o,
  output logic [P-1:0] fault_idx_q_o
);

  inj_state_e   inj_state;
  logic         arm_en;
  logic [R-1:0] sel_lines;
  logic         fire;
  logic [R-1:0] bank_d;
  logic [R-1:0] bank_q;
  logic [P-1:0] idx_q, idx_d;
  logic         idx_en;

  assign arm_en = (inj_state == INJ_ARMED);

  flip_sel_decoder #(.P(P), .R(R)) dec_i (
    .idx_i   (fault_idx_i),
    .enable_i(arm_en),
    .sel_o   (sel_lines)
  );

  assign fire = |sel_lines;

  flip_once_latch latch_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .fire_i (fire),
    .state_o(inj_state)
  );

  flip_mux_bank #(.R(R)) mux_i (
    .d_i  (d_i),
    .sel_i(sel_lines),
    .mux_o(bank_d)
  );

  // Target bank registers.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bank_q <= '0;
    end else begin
      bank_q <= bank_d;
    end
  end

  // Recorded index: loaded only on the firing cycle.
  assign idx_en = fire;
  always_comb begin
    idx_d = idx_q;
    if (idx_en) begin
      idx_d = fault_idx_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= '0;
    end else begin
      idx_q <= idx_d;
    end
  end

  assign q_o           = bank_q;
  assign injected_o    = (inj_state == INJ_SPENT);
  assign fault_idx_q_o = idx_q;

endmodule

// File: rtl/flip_once_checker.sv
module flip_once_checker #(
  parameter int unsigned R = 8,
  parameter int unsigned P = 4
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic [P-1:0] fault_idx_i,
  input logic [R-1:0] d_i,
  input logic [R-1:0] q_o,
  input logic         injected_o,
  input logic [P-1:0] fault_idx_q_o,
  input logic [R-1:0] sel_lines
);

  localparam logic [P-1:0] IDX_TOP = P'(R);

  logic in_range;
  assign in_range = (fault_idx_i != '0) && (fault_idx_i <= IDX_TOP);

  AST_SEL_ONEHOT0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(sel_lines)); // R3

  AST_ZERO_IDX_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_idx_i == '0) |=> (q_o == $past(d_i))); // R2

  AST_FIRST_FLIP_ONE_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!injected_o && in_range) |=> (injected_o && ($countones(q_o ^ $past(d_i)) == 1))); // R4

  AST_FLAG_STICKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    injected_o |=> injected_o); // R5

  AST_SPENT_NO_SEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    injected_o |-> (sel_lines == '0)); // R6

  AST_SPENT_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    injected_o |=> (q_o == $past(d_i))); // R6

  AST_OUT_OF_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!injected_o && fault_idx_i > IDX_TOP) |=> (!injected_o && q_o == $past(d_i))); // R7

  AST_IDX_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    injected_o |=> $stable(fault_idx_q_o)); // R8

  AST_IDX_ZERO_ARMED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !injected_o |-> (fault_idx_q_o == '0)); // R8

endmodule

bind flip_once_injector flip_once_checker #(.R(R), .P(P)) chk_i (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .fault_idx_i  (fault_idx_i),
  .d_i          (d_i),
  .q_o          (q_o),
  .injected_o   (injected_o),
  .fault_idx_q_o(fault_idx_q_o),
  .sel_lines    (sel_lines)
);

// File: tb/flip_once_injector_tb_top.sv
module flip_once_injector_tb_top;

  localparam int R = 8;
  localparam int P = 4;
  localparam time CLK_PERIOD = 10ns;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic [P-1:0] fault_idx_i = '0;
  logic [R-1:0] d_i = '0;
  logic [R-1:0] q_o;
  logic         injected_o;
  logic [P-1:0] fault_idx_q_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Reference model state
  bit m_inj;
  int m_idx;
  int run_flips;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  flip_once_injector #(.R(R), .P(P)) dut_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .fault_idx_i  (fault_idx_i),
    .d_i          (d_i),
    .q_o          (q_o),
    .injected_o   (injected_o),
    .fault_idx_q_o(fault_idx_q_o)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    fault_idx_i = '0;
    #1;
    chk("R1", "bank in reset", int'(q_o), 0);
    chk("R1", "flag in reset", int'(injected_o), 0);
    chk("R1", "index in reset", int'(fault_idx_q_o), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    m_inj = 1'b0;
    m_idx = 0;
    run_flips = 0;
  endtask

  // One cycle: drive at negedge, model at posedge, compare at next negedge.
  task automatic step(input int idx, input string req);
    logic [R-1:0] flip;
    logic [R-1:0] d_now;
    logic [R-1:0] exp_q;
    fault_idx_i = P'(idx);
    d_i = R'($urandom);
    d_now = d_i;
    @(posedge clk_i);
    flip = '0;
    if (!m_inj && idx >= 1 && idx <= R) begin
      flip = R'(1) << (idx - 1);
      m_inj = 1'b1;
      m_idx = idx;
    end
    exp_q = d_now ^ flip;
    @(negedge clk_i);
    chk(req, "bank", int'(q_o), int'(exp_q));
    chk(req, "flag", int'(injected_o), int'(m_inj));
    chk(req, "index", int'(fault_idx_q_o), m_idx);
    chk("R3", "flipped bits", $countones(q_o ^ d_now), $countones(flip));
    if (q_o != d_now) run_flips++;
  endtask

  task automatic end_run(input string req);
    chk(req, "flip cycles in run", run_flips, 1);
  endtask

  initial begin
    m_inj = 1'b0;
    m_idx = 0;
    run_flips = 0;
    do_reset();
    // R2: zero index passes values through
    for (int i = 0; i < 20; i++) step(0, "R2");
    // R7: indices above R never fire
    for (int k = R + 1; k < (1 << P); k++) step(k, "R7");
    for (int i = 0; i < 10; i++) step(int'($urandom_range(R + 1, (1 << P) - 1)), "R7");
    // R4: first in-range index flips its bit
    step(3, "R4");
    // R5/R6/R8: later requests are blocked, flag and index hold
    for (int i = 0; i < 20; i++) step(int'($urandom_range(0, (1 << P) - 1)), "R6");
    for (int k = 1; k <= R; k++) step(k, "R5");
    end_run("R4");
    // R9: reset re-arms; top boundary index R
    do_reset();
    step(0, "R9");
    step(R, "R9");
    step(1, "R6");
    step(R, "R8");
    end_run("R9");
    // Low boundary index 1 right after reset
    do_reset();
    step(1, "R4");
    for (int i = 0; i < 8; i++) step(int'($urandom_range(1, R)), "R6");
    end_run("R4");
    // Every index in range, one run each
    for (int k = 1; k <= R; k++) begin
      do_reset();
      step(0, "R2");
      step(k, "R4");
      step(k, "R6");
      end_run("R4");
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule